// File: doc/BRIEF.md
# Load Data Alignment and Extension

This combinational unit turns the raw 32-bit word returned by a memory read into the value that is written back to the register file. It takes the low address bits of the access and an encoded access kind. Word reads at an unaligned address are not split and do not raise a fault. Instead the aligned word is rotated so that the addressed byte lands in bits [7:0]. Byte and halfword reads pick the addressed lane and widen it to 32 bits with zero or sign fill. The unit is little-endian: byte 0 sits in bits [7:0].

The unit sits between the load data return path and register writeback in a processor pipeline. The read half of an atomic swap uses the same rotation as a word load. A word load whose destination is the program counter can have bit 0 of its result forced to zero. This is chosen at build time for the older core variant. The unit holds no state and has no clock. The load result is meant to be registered by the writeback stage that follows, so no valid/ready handshake is added at its edge: the result follows the inputs in the same cycle.

Top module: `load_align_ext`

## Requirements
- R1: With kind code 3'b000 (word), the output is `rd_word` rotated right by 8×`addr_lo` bits, `addr_lo` being address bits [1:0]; byte 0 is bits [7:0].
- R2: With kind code 3'b101 (swap read), the output is the same rotation as R1, and `dest_is_pc` has no effect on it.
- R3: With kind code 3'b001 (unsigned byte), bits [7:0] of the output are byte lane `addr_lo` of `rd_word` (lane k = bits [8k+7:8k]) and bits [31:8] are zero.
- R4: With kind code 3'b010 (signed byte), bits [7:0] are chosen as in R3 and bits [31:8] all equal bit 7 of that byte.
- R5: With kind code 3'b011 (unsigned halfword), bits [15:0] are halfword lane `addr_lo[1]` (lane 0 = bits [15:0], lane 1 = bits [31:16]), `addr_lo[0]` is ignored, and bits [31:16] are zero.
- R6: With kind code 3'b100 (signed halfword), bits [15:0] are chosen as in R5 and bits [31:16] all equal bit 15 of that halfword.
- R7: With PC_LSB_CLEAR=1, a word load (code 3'b000) with `dest_is_pc`=1 gives the R1 result with bit 0 forced to 0. For every other kind code, `dest_is_pc` does not change the output.
- R8: Kind codes 3'b110 and 3'b111 drive an all-zero output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rd_word | input | 32 | Aligned word returned by the memory read |
| addr_lo | input | 2 | Low address bits of the access (byte offset in the word) |
| kind | input | 3 | Access kind code (see R1 to R8) |
| dest_is_pc | input | 1 | The destination register is the program counter |
| wb_data | output | 32 | Aligned and extended writeback value |

## Verification
The bench builds the unit with its default parameters: 8-bit lanes, four lanes per word and PC_LSB_CLEAR=1. This configuration keeps the input space small. The bench therefore sweeps every kind code, every byte offset and both states of the program-counter flag over a set of data words. Those words are chosen so that each lane has a distinct value and each sign bit is seen both set and clear. This covers all four rotation amounts, the sign and zero fill of every lane, the ignored address bit for halfwords, the masked bit 0 and the zero output of the unused codes. Each expected value is computed with shifts and masks in the bench.

// File: rtl/ldx_pkg.sv
`timescale 1ns/1ps
package ldx_pkg;
  // Access kind codes decoded by the alignment unit.
  typedef enum logic [2:0] {
    KIND_WORD  = 3'b000,
    KIND_UBYTE = 3'b001,
    KIND_SBYTE = 3'b010,
    KIND_UHALF = 3'b011,
    KIND_SHALF = 3'b100,
    KIND_SWAP  = 3'b101
  } ldx_kind_e;
endpackage

// File: rtl/ldx_rotator.sv
`timescale 1ns/1ps
// Rotates a word right by whole lanes: output lane o takes input lane (o+sh) mod LANES.
module ldx_rotator #(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  localparam int DW    = LANE_W * LANES,
  localparam int SW    = $clog2(LANES)
) (
  input  logic [DW-1:0] din,
  input  logic [SW-1:0] sh,
  output logic [DW-1:0] dout
);
  for (genvar o = 0; o < LANES; o++) begin : g_lane
    logic [SW-1:0] src;
    assign src = SW'(o) + sh;
    assign dout[o*LANE_W +: LANE_W] = din[src*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/ldx_extend.sv
`timescale 1ns/1ps
// Widens a narrow field to the full word with zero or sign fill.
module ldx_extend #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 32
) (
  input  logic [IN_W-1:0]  val,
  input  logic             sign_en,
  output logic [OUT_W-1:0] dout
);
  logic fill;
  assign fill = sign_en & val[IN_W-1];
  assign dout = {{(OUT_W-IN_W){fill}}, val};
endmodule

// File: rtl/load_align_ext.sv
`timescale 1ns/1ps
module load_align_ext #(
  parameter int LANE_W       = 8,
  parameter int LANES        = 4,
  parameter bit PC_LSB_CLEAR = 1'b1,
  localparam int DW          = LANE_W * LANES,
  localparam int AW          = $clog2(LANES),
  localparam int HW          = 2 * LANE_W,
  localparam int HAW         = AW - 1
) (
  input  logic [DW-1:0] rd_word,
  input  logic [AW-1:0] addr_lo,
  input  logic [2:0]    kind,
  input  logic          dest_is_pc,
  output logic [DW-1:0] wb_data
);
  import ldx_pkg::*;

  ldx_kind_e     kind_e;
  logic [DW-1:0] rot_word;
  logic [DW-1:0] word_res;
  logic [LANE_W-1:0] byte_lane;
  logic [HW-1:0]     half_lane;
  logic [HAW-1:0]    half_sel;
  logic [DW-1:0]     byte_ext;
  logic [DW-1:0]     half_ext;
  logic              byte_signed;
  logic              half_signed;

  assign kind_e = ldx_kind_e'(kind);

  ldx_rotator #(.LANE_W(LANE_W), .LANES(LANES)) u_rot (
    .din  (rd_word),
    .sh   (addr_lo),
    .dout (rot_word)
  );

  // Lane pick: byte by full offset, halfword by the offset without its low bit.
  assign half_sel  = addr_lo[AW-1:1];
  assign byte_lane = rd_word[addr_lo*LANE_W +: LANE_W];
  assign half_lane = rd_word[half_sel*HW +: HW];

  assign byte_signed = (kind_e == KIND_SBYTE);
  assign half_signed = (kind_e == KIND_SHALF);

  ldx_extend #(.IN_W(LANE_W), .OUT_W(DW)) u_ext_b (
    .val     (byte_lane),
    .sign_en (byte_signed),
    .dout    (byte_ext)
  );

  ldx_extend #(.IN_W(HW), .OUT_W(DW)) u_ext_h (
    .val     (half_lane),
    .sign_en (half_signed),
    .dout    (half_ext)
  );

  // Program-counter destination masking, chosen at build time.
  if (PC_LSB_CLEAR) begin : g_pc_mask
    assign word_res = {rot_word[DW-1:1], rot_word[0] & ~dest_is_pc};
  end else begin : g_pc_pass
    assign word_res = rot_word;
  end

  always_comb begin
    unique case (kind_e)
      KIND_WORD:              wb_data = word_res;
      KIND_SWAP:              wb_data = rot_word;
      KIND_UBYTE, KIND_SBYTE: wb_data = byte_ext;
      KIND_UHALF, KIND_SHALF: wb_data = half_ext;
      default:                wb_data = '0;
    endcase
  end
endmodule

// File: rtl/load_align_ext_chk.sv
`timescale 1ns/1ps
module load_align_ext_chk #(
  parameter int LANE_W       = 8,
  parameter int LANES        = 4,
  parameter bit PC_LSB_CLEAR = 1'b1,
  localparam int DW          = LANE_W * LANES,
  localparam int AW          = $clog2(LANES),
  localparam int HW          = 2 * LANE_W
) (
  input logic [DW-1:0] rd_word,
  input logic [AW-1:0] addr_lo,
  input logic [2:0]    kind,
  input logic          dest_is_pc,
  input logic [DW-1:0] wb_data
);
  logic [2*DW-1:0] dbl;
  logic [DW-1:0]   rot_ref;
  logic            pc_mask;

  always_comb begin
    dbl     = {rd_word, rd_word} >> (int'(addr_lo) * LANE_W);
    rot_ref = dbl[DW-1:0];
    pc_mask = PC_LSB_CLEAR & dest_is_pc;

    // R1 / R7: word result is the rotation, low bit cleared for PC loads
    if (kind == 3'b000) begin
      a_r1_word_rotate: assert (wb_data[DW-1:1] == rot_ref[DW-1:1] &&
                                wb_data[0] == (rot_ref[0] & ~pc_mask))
        else $error("word rotation mismatch");
    end
    // R2: swap read rotates and ignores the PC flag
    if (kind == 3'b101) begin
      a_r2_swap_rotate: assert (wb_data == rot_ref)
        else $error("swap rotation mismatch");
    end
    // R3 / R5: unsigned kinds zero-fill
    if (kind == 3'b001) begin
      a_r3_ubyte_zero: assert (wb_data[DW-1:LANE_W] == '0)
        else $error("unsigned byte not zero-filled");
    end
    if (kind == 3'b011) begin
      a_r5_uhalf_zero: assert (wb_data[DW-1:HW] == '0)
        else $error("unsigned halfword not zero-filled");
    end
    // R4 / R6: signed kinds replicate the field sign bit
    if (kind == 3'b010) begin
      a_r4_sbyte_fill: assert (wb_data[DW-1:LANE_W] == {(DW-LANE_W){wb_data[LANE_W-1]}})
        else $error("signed byte fill wrong");
    end
    if (kind == 3'b100) begin
      a_r6_shalf_fill: assert (wb_data[DW-1:HW] == {(DW-HW){wb_data[HW-1]}})
        else $error("signed halfword fill wrong");
    end
    // R8: unused codes give zero
    if (kind == 3'b110 || kind == 3'b111) begin
      a_r8_unused_zero: assert (wb_data == '0)
        else $error("unused kind not zero");
    end
  end
endmodule

bind load_align_ext load_align_ext_chk #(
  .LANE_W(LANE_W), .LANES(LANES), .PC_LSB_CLEAR(PC_LSB_CLEAR)
) u_chk (
  .rd_word(rd_word), .addr_lo(addr_lo), .kind(kind),
  .dest_is_pc(dest_is_pc), .wb_data(wb_data)
);

// File: tb/load_align_ext_bench.sv
`timescale 1ns/1ps
module load_align_ext_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] rd_word = '0;
  logic [1:0]  addr_lo = '0;
  logic [2:0]  kind = '0;
  logic        dest_is_pc = 1'b0;
  logic [31:0] wb_data;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  load_align_ext u_load_align_ext (
    .rd_word(rd_word), .addr_lo(addr_lo), .kind(kind),
    .dest_is_pc(dest_is_pc), .wb_data(wb_data)
  );

  function automatic logic [31:0] model(input logic [31:0] d, input logic [1:0] a,
                                        input logic [2:0] k, input logic pc);
    logic [31:0] r, b, h;
    int s;
    s = 8 * int'(a);
    r = (d >> s) | (d << (32 - s));
    b = (d >> s) & 32'h0000_00FF;
    h = (d >> (16 * int'(a[1]))) & 32'h0000_FFFF;
    case (k)
      3'b000:  return pc ? (r & 32'hFFFF_FFFE) : r;
      3'b101:  return r;
      3'b001:  return b;
      3'b010:  return b[7] ? (b | 32'hFFFF_FF00) : b;
      3'b011:  return h;
      3'b100:  return h[15] ? (h | 32'hFFFF_0000) : h;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_name(input logic [2:0] k, input logic pc);
    if (pc && k != 3'b000 && k != 3'b101) return "R7";
    case (k)
      3'b000:  return pc ? "R7" : "R1";
      3'b101:  return "R2";
      3'b001:  return "R3";
      3'b010:  return "R4";
      3'b011:  return "R5";
      3'b100:  return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic apply_check(input logic [31:0] d, input logic [1:0] a,
                             input logic [2:0] k, input logic pc, input string req);
    logic [31:0] exp;
    @(negedge clk);
    rd_word = d; addr_lo = a; kind = k; dest_is_pc = pc;
    exp = model(d, a, k, pc);
    @(posedge clk);
    #1;
    n_checks++;
    if (wb_data !== exp) begin
      n_fail++;
      $display("FAIL %s data=%h addr=%0d kind=%0d pc=%0b actual=%h expected=%h",
               req, d, a, k, pc, wb_data, exp);
    end
  endtask

  logic [31:0] pats [8] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8070_FF01,
                            32'h4433_2211, 32'h7F80_807F, 32'hDEAD_BEEF,
                            32'h0180_7F81, 32'hA5C3_3C5A};

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle state: all-zero inputs give zero (R1)
    apply_check(32'h0, 2'd0, 3'b000, 1'b0, "R1");
    foreach (pats[p]) begin
      for (int a = 0; a < 4; a++) begin
        for (int k = 0; k < 8; k++) begin
          for (int pc = 0; pc < 2; pc++) begin
            apply_check(pats[p], 2'(a), 3'(k), 1'(pc), req_name(3'(k), 1'(pc)));
          end
        end
      end
    end
    // R5: addr_lo[0] ignored for halfwords, explicit pair
    apply_check(32'h1234_8765, 2'd3, 3'b011, 1'b0, "R5");
    apply_check(32'h1234_8765, 2'd1, 3'b100, 1'b0, "R6");
    // R7: odd rotated word loaded to PC loses bit 0
    apply_check(32'h0000_0300, 2'd1, 3'b000, 1'b1, "R7");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule